// File: doc/BRIEF.md
# Switching Controller Protection Sequencer

This block is the supervisor that decides whether a bridge timing core is allowed to switch. It takes already-debounced digital flags: supply above its start level, supply below its stop level, enable, latching shutdown, overcurrent and short circuit. It also takes a soft-start step size. From these it drives a digital soft-start ramp, a run/stop output and a pulse-terminate output. A three-bit status code reports which of five states the sequencer is in.

The supply flag has hysteresis. The sequencer leaves its hold state only after the supply has crossed the start level, and it falls back to hold only on a stop-level crossing. Each start passes through a saturating ramp before full operation. An overcurrent flag cuts the present switching pulse but does not change the state. A short circuit starts a timed hiccup pause, after which a fresh soft-start begins on its own. A latching shutdown stops the controller until the supply drops below its stop level. The enable input is non-latching.

Top module: `prot_seq`

## Requirements
- R1: An internal supply-good flag is set by `above_start` and cleared by `below_stop`. When both are high, `below_stop` wins. When neither is high, the flag holds. The sequencer cannot leave the hold state while the flag is clear.
- R2: From hold, with supply good, `enable` high and `latch_sd` low, the next state is soft-start with `ss_level` = 0. In each soft-start cycle, `ss_level` adds `ss_step` (a step of 0 counts as 1) and saturates at all ones. The cycle after `ss_level` is all ones, the state becomes run. With a step of 1, soft-start therefore lasts 2^SS_W cycles.
- R3: While supply is good, `latch_sd` high moves any state to latched, and `ss_level` becomes 0. Latched ignores `enable`, `latch_sd`, `short_ckt` and `above_start`. It is left only through R7.
- R4: `enable` low in soft-start, run or hiccup returns to hold with `ss_level` = 0. Raising it again restarts soft-start from 0.
- R5: In soft-start or run, `pulse_end` equals `overcurrent` in the same cycle. `overcurrent` never changes the state. Outside those states `pulse_end` is 0.
- R6: `short_ckt` high in soft-start or run moves to hiccup with `ss_level` = 0. Hiccup lasts exactly HIC_CYCLES cycles and then enters soft-start from 0. `short_ckt` is ignored during hiccup.
- R7: `below_stop` high moves any state, latched included, to hold with `ss_level` = 0.
- R8: `state_code` reads 0 for hold, 1 for soft-start, 2 for run, 3 for hiccup and 4 for latched. `run` is high exactly in states 1 and 2.
- R9: Priority order, highest first: `below_stop`, then `latch_sd`, then `short_ckt`, then `enable` low.
- R10: After reset, `state_code` = 0, `ss_level` = 0, `run` = 0 and the supply-good flag is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| above_start | input | 1 | Supply is above the start level |
| below_stop | input | 1 | Supply is below the stop level |
| enable | input | 1 | Non-latching enable |
| latch_sd | input | 1 | Latching shutdown request |
| overcurrent | input | 1 | Cycle-by-cycle current limit flag |
| short_ckt | input | 1 | Short-circuit flag |
| ss_step | input | SS_W | Soft-start increment per cycle (0 counts as 1) |
| ss_level | output | SS_W | Soft-start ramp value |
| run | output | 1 | Timing core may switch |
| pulse_end | output | 1 | Terminate the present switching pulse |
| state_code | output | 3 | Sequencer state |

## Verification
The bench builds the block with SS_W = 6 and HIC_CYCLES = 12. A full ramp at step 1 then takes 64 cycles and a hiccup pause takes 12. Both can be counted exactly in directed runs, and the long random run still passes through many restarts. Because the ramp is narrow, random steps from 0 to 7 also reach the saturation corner, where the last add overshoots all ones. Rare random stop crossings and latch requests keep latched episodes short, so all five states and every priority collision come up many times.

// File: rtl/prot_seq_pkg.sv
package prot_seq_pkg;
  typedef enum logic [2:0] {
    PS_HOLD   = 3'd0,
    PS_SOFT   = 3'd1,
    PS_RUN    = 3'd2,
    PS_HICCUP = 3'd3,
    PS_LATCH  = 3'd4
  } ps_state_t;
endpackage

// File: rtl/prot_seq_supply.sv
module prot_seq_supply (
  input  logic clk,
  input  logic rst_n,
  input  logic above_start,
  input  logic below_stop,
  output logic sup_ok_nxt,
  output logic sup_ok_q
);
  // hysteresis: stop crossing dominates, otherwise hold
  always_comb begin
    if (below_stop)       sup_ok_nxt = 1'b0;
    else if (above_start) sup_ok_nxt = 1'b1;
    else                  sup_ok_nxt = sup_ok_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sup_ok_q <= 1'b0;
    else        sup_ok_q <= sup_ok_nxt;
  end

  p_stop_wins_r1: assert property (@(posedge clk) disable iff (!rst_n)
    below_stop |=> !sup_ok_q);
  p_start_sets_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (above_start && !below_stop) |=> sup_ok_q);
endmodule

// File: rtl/prot_seq_ramp.sv
module prot_seq_ramp #(
  parameter int SS_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            adv,
  input  logic [SS_W-1:0] step,
  output logic [SS_W-1:0] level,
  output logic            full
);
  localparam logic [SS_W-1:0] LVL_MAX = {SS_W{1'b1}};

  logic [SS_W-1:0] step_eff;
  logic [SS_W:0]   sum;
  logic [SS_W-1:0] level_d;
  logic            level_en;

  always_comb begin
    step_eff = (step == '0) ? {{(SS_W-1){1'b0}}, 1'b1} : step;
    sum      = {1'b0, level} + {1'b0, step_eff};
    level_en = clr | adv;
    if (clr)         level_d = '0;
    else if (sum[SS_W]) level_d = LVL_MAX;
    else             level_d = sum[SS_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        level <= '0;
    else if (level_en) level <= level_d;
  end

  assign full = (level == LVL_MAX);

  p_ramp_rises_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !clr && !full) |=> (level > $past(level)));
  p_ramp_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (level == '0));
endmodule

// File: rtl/prot_seq_timer.sv
module prot_seq_timer #(
  parameter int HIC_CYCLES = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic active,
  output logic done
);
  localparam int CW = $clog2(HIC_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(HIC_CYCLES - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = load | (active & ~done);
    cnt_d  = load ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign done = (cnt_q == LAST);

  p_cnt_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
endmodule

// File: rtl/prot_seq.sv
module prot_seq
  import prot_seq_pkg::*;
#(
  parameter int SS_W       = 8,
  parameter int HIC_CYCLES = 1000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            above_start,
  input  logic            below_stop,
  input  logic            enable,
  input  logic            latch_sd,
  input  logic            overcurrent,
  input  logic            short_ckt,
  input  logic [SS_W-1:0] ss_step,
  output logic [SS_W-1:0] ss_level,
  output logic            run,
  output logic            pulse_end,
  output logic [2:0]      state_code
);
  ps_state_t st_q, st_d;
  logic sup_ok_nxt, sup_ok_q;
  logic ramp_clr, ramp_adv, ramp_full;
  logic hic_load, hic_done;

  prot_seq_supply u_sup (
    .clk(clk), .rst_n(rst_n), .above_start(above_start),
    .below_stop(below_stop), .sup_ok_nxt(sup_ok_nxt), .sup_ok_q(sup_ok_q)
  );

  prot_seq_ramp #(.SS_W(SS_W)) u_ramp (
    .clk(clk), .rst_n(rst_n), .clr(ramp_clr), .adv(ramp_adv),
    .step(ss_step), .level(ss_level), .full(ramp_full)
  );

  prot_seq_timer #(.HIC_CYCLES(HIC_CYCLES)) u_hic (
    .clk(clk), .rst_n(rst_n), .load(hic_load),
    .active(st_q == PS_HICCUP), .done(hic_done)
  );

  // next state: supply loss > latch > short > enable low
  always_comb begin
    st_d     = st_q;
    ramp_clr = 1'b0;
    ramp_adv = 1'b0;
    hic_load = 1'b0;
    if (!sup_ok_nxt) begin
      st_d     = PS_HOLD;
      ramp_clr = 1'b1;
    end else if (st_q == PS_LATCH) begin
      st_d = PS_LATCH;
    end else if (latch_sd) begin
      st_d     = PS_LATCH;
      ramp_clr = 1'b1;
    end else begin
      case (st_q)
        PS_HOLD: begin
          if (enable) begin
            st_d     = PS_SOFT;
            ramp_clr = 1'b1;
          end
        end
        PS_SOFT, PS_RUN: begin
          if (short_ckt) begin
            st_d     = PS_HICCUP;
            ramp_clr = 1'b1;
            hic_load = 1'b1;
          end else if (!enable) begin
            st_d     = PS_HOLD;
            ramp_clr = 1'b1;
          end else if (st_q == PS_SOFT) begin
            if (ramp_full) st_d = PS_RUN;
            else           ramp_adv = 1'b1;
          end
        end
        PS_HICCUP: begin
          if (!enable) begin
            st_d     = PS_HOLD;
            ramp_clr = 1'b1;
          end else if (hic_done) begin
            st_d     = PS_SOFT;
            ramp_clr = 1'b1;
          end
        end
        default: begin
          st_d     = PS_HOLD;
          ramp_clr = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= PS_HOLD;
    else        st_q <= st_d;
  end

  assign run        = (st_q == PS_SOFT) || (st_q == PS_RUN);
  assign pulse_end  = run & overcurrent;
  assign state_code = st_q;

  p_latch_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PS_LATCH && !below_stop) |=> (st_q == PS_LATCH));
  p_run_from_soft_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PS_RUN && $past(st_q) != PS_RUN) |-> ($past(st_q) == PS_SOFT && $past(ramp_full)));
  p_hold_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PS_HOLD) |-> (ss_level == '0));
  p_hic_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PS_HICCUP && $past(st_q) != PS_HICCUP) |-> $past(short_ckt));
  p_ocp_keeps_run_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PS_RUN && overcurrent && enable && !short_ckt && !latch_sd && !below_stop)
      |=> (st_q == PS_RUN));
endmodule

// File: tb/sim_prot_seq.sv
module sim_prot_seq;
  localparam int W    = 6;
  localparam int HIC  = 12;
  localparam int MAXV = (1 << W) - 1;

  logic clk = 1'b0;
  logic rst_n;
  logic above_start, below_stop, enable, latch_sd, overcurrent, short_ckt;
  logic [W-1:0] ss_step;
  logic [W-1:0] ss_level;
  logic run, pulse_end;
  logic [2:0] state_code;

  int n_chk = 0;
  int n_bad = 0;
  string cur_req = "R10";

  int m_st, m_ss, m_hc;
  bit m_sup;

  always #4 clk = ~clk;

  prot_seq #(.SS_W(W), .HIC_CYCLES(HIC)) u0 (
    .clk(clk), .rst_n(rst_n), .above_start(above_start), .below_stop(below_stop),
    .enable(enable), .latch_sd(latch_sd), .overcurrent(overcurrent),
    .short_ckt(short_ckt), .ss_step(ss_step), .ss_level(ss_level),
    .run(run), .pulse_end(pulse_end), .state_code(state_code)
  );

  task automatic chk(bit ok, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s act=%0d exp=%0d", cur_req, what, act, exp);
    end
  endtask

  function automatic int sat_add(int lvl, int stp);
    int s;
    s = lvl + ((stp == 0) ? 1 : stp);
    return (s > MAXV) ? MAXV : s;
  endfunction

  // reference model, one clock edge, from R1..R9
  task automatic model_edge();
    bit sn;
    sn = below_stop ? 1'b0 : (above_start ? 1'b1 : m_sup);
    m_sup = sn;
    if (!sn) begin m_st = 0; m_ss = 0; end
    else if (m_st == 4) m_st = 4;
    else if (latch_sd) begin m_st = 4; m_ss = 0; end
    else begin
      case (m_st)
        0: if (enable) begin m_st = 1; m_ss = 0; end
        1, 2: begin
          if (short_ckt) begin m_st = 3; m_ss = 0; m_hc = 0; end
          else if (!enable) begin m_st = 0; m_ss = 0; end
          else if (m_st == 1) begin
            if (m_ss == MAXV) m_st = 2;
            else m_ss = sat_add(m_ss, int'(ss_step));
          end
        end
        default: begin
          if (!enable) begin m_st = 0; m_ss = 0; end
          else if (m_hc == HIC - 1) begin m_st = 1; m_ss = 0; end
          else m_hc++;
        end
      endcase
    end
  endtask

  task automatic compare();
    bit exp_run;
    exp_run = (m_st == 1) || (m_st == 2);
    chk(int'(state_code) == m_st, "state_code", int'(state_code), m_st);
    chk(int'(ss_level) == m_ss, "ss_level", int'(ss_level), m_ss);
    chk(run == exp_run, "run R8", int'(run), int'(exp_run));
    chk(pulse_end == (exp_run & overcurrent), "pulse_end R5",
        int'(pulse_end), int'(exp_run & overcurrent));
  endtask

  task automatic tick();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare();
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    int cnt;
    void'($urandom(32'd1234));
    rst_n = 1'b0;
    {above_start, below_stop, enable, latch_sd, overcurrent, short_ckt} = '0;
    ss_step = '0;
    m_st = 0; m_ss = 0; m_hc = 0; m_sup = 1'b0;
    repeat (3) @(negedge clk);
    cur_req = "R10";
    compare();
    rst_n = 1'b1;

    // R1: no start crossing yet, enable alone does nothing
    cur_req = "R1";
    enable = 1'b1;
    repeat (5) tick();
    chk(state_code == 3'd0, "hold without supply R1", int'(state_code), 0);
    above_start = 1'b1; below_stop = 1'b1;
    tick();
    chk(state_code == 3'd0, "stop wins R1", int'(state_code), 0);
    below_stop = 1'b0;
    tick();
    above_start = 1'b0;
    chk(state_code == 3'd1, "start after crossing R1", int'(state_code), 1);

    // R2: step 0 acts as 1, soft-start length 2^W cycles
    cur_req = "R2";
    cnt = 1;
    for (int i = 0; i < 200 && state_code == 3'd1; i++) begin
      tick();
      if (state_code == 3'd1) cnt++;
    end
    chk(cnt == MAXV + 1, "soft-start length R2", cnt, MAXV + 1);
    chk(state_code == 3'd2, "run after ramp R2", int'(state_code), 2);

    // R5: overcurrent ends pulse, state kept
    cur_req = "R5";
    overcurrent = 1'b1;
    repeat (3) tick();
    chk(pulse_end == 1'b1 && state_code == 3'd2, "ocp in run R5", int'(state_code), 2);
    overcurrent = 1'b0;

    // R6: hiccup length and restart
    cur_req = "R6";
    short_ckt = 1'b1;
    tick();
    chk(state_code == 3'd3, "enter hiccup R6", int'(state_code), 3);
    cnt = 1;
    for (int i = 0; i < 100 && state_code == 3'd3; i++) begin
      tick();
      short_ckt = 1'b0;
      if (state_code == 3'd3) cnt++;
    end
    chk(cnt == HIC, "hiccup length R6", cnt, HIC);
    chk(state_code == 3'd1 && ss_level == 0, "restart soft R6", int'(state_code), 1);

    // R4: enable drop in soft-start
    cur_req = "R4";
    repeat (4) tick();
    enable = 1'b0;
    tick();
    chk(state_code == 3'd0 && ss_level == 0, "enable low R4", int'(state_code), 0);
    enable = 1'b1;
    tick();
    chk(state_code == 3'd1 && ss_level == 0, "re-enable R4", int'(state_code), 1);
    ss_step = W'(5);
    repeat (20) tick();

    // R9: latch beats short
    cur_req = "R9";
    latch_sd = 1'b1; short_ckt = 1'b1;
    tick();
    chk(state_code == 3'd4 && run == 1'b0, "latch priority R9", int'(state_code), 4);
    latch_sd = 1'b0; short_ckt = 1'b0;

    // R3: latched ignores everything but stop crossing
    cur_req = "R3";
    for (int i = 0; i < 10; i++) begin
      enable = i[0]; above_start = i[1];
      tick();
    end
    chk(state_code == 3'd4, "latched holds R3", int'(state_code), 4);
    enable = 1'b1; above_start = 1'b0;

    // R7: stop crossing clears everything
    cur_req = "R7";
    below_stop = 1'b1;
    tick();
    chk(state_code == 3'd0 && ss_level == 0, "stop to hold R7", int'(state_code), 0);
    below_stop = 1'b0;
    repeat (3) tick();
    chk(state_code == 3'd0, "stays in hold R7", int'(state_code), 0);

    // R8: random mix
    cur_req = "R8";
    for (int i = 0; i < 4000; i++) begin
      above_start = ($urandom % 4) == 0;
      below_stop  = ($urandom % 60) == 0;
      enable      = ($urandom % 25) != 0;
      latch_sd    = ($urandom % 300) == 0;
      short_ckt   = ($urandom % 40) == 0;
      overcurrent = ($urandom % 3) == 0;
      ss_step     = W'($urandom % 8);
      tick();
    end

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule